// File: doc/BRIEF.md
# Four-Point Fixed-Point Inverse DCT

This block computes a one-dimensional four-point inverse discrete cosine transform on four signed 16-bit coefficients. It uses integer cosine constants with 14 fractional bits. The result is four signed 16-bit samples. The arithmetic is fixed so that it matches a reference integer model bit for bit. Each multiply-accumulate keeps its full-width product. It is then rounded half up, shifted right by 14 and clamped to the signed 16-bit range. The sums around the products wrap at 16 bits and do not saturate.

A producer presents the four coefficient lanes together with `in_valid`. One clock later the four transformed lanes appear on registered outputs, and `out_valid` is high. When `in_valid` is low the output registers keep their previous contents. A larger 2-D transform can therefore run this block on rows and columns with its own transposition around it.

Top module: `idct4_q14`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and all four output lanes are cleared to zero on that edge.
- R2: `out_valid` at each rising edge takes the value of `in_valid` sampled at that edge. The result for an accepted input therefore appears exactly one clock later.
- R3: An edge where `in_valid` is low leaves all four output lanes unchanged.
- R4: The even-part terms are e = in0 + in2 and d = in0 − in2, taken modulo 2^16 as signed 16-bit values, so 32767 + 1 gives −32768.
- R5: Four step terms are formed at full precision with K1 = 15137, K2 = 11585 and K3 = 6270:
  - p0 = e·K2
  - p1 = d·K2
  - p2 = in1·K3 − in3·K1
  - p3 = in1·K1 + in3·K3
- R6: Each step term is narrowed as floor((p + 8192) / 16384), so exact halves round toward positive infinity.
- R7: A narrowed step term above 32767 becomes 32767, and one below −32768 becomes −32768.
- R8: With s0..s3 the narrowed steps, the outputs are computed modulo 2^16:
  - y0 = s0 + s3
  - y1 = s1 + s2
  - y2 = s1 − s2
  - y3 = s0 − s3

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient lanes hold a vector to transform |
| in_c0 | input | 16 | Coefficient 0 (DC), signed |
| in_c1 | input | 16 | Coefficient 1, signed |
| in_c2 | input | 16 | Coefficient 2, signed |
| in_c3 | input | 16 | Coefficient 3, signed |
| out_valid | output | 1 | Output lanes hold a fresh result |
| out_y0 | output | 16 | Output sample 0, signed |
| out_y1 | output | 16 | Output sample 1, signed |
| out_y2 | output | 16 | Output sample 2, signed |
| out_y3 | output | 16 | Output sample 3, signed |

## Verification
The assertions take one thing for granted: the coefficient lanes are stable around the sampling edge whenever `in_valid` is high. They also assume that the narrowed steps seen inside relate to the registered outputs through wrapping sums and differences, whatever the input values are. No range limit on the inputs is assumed. The bench changes inputs only on falling edges and samples outputs on the following falling edge. Its random vectors use the full signed range, and directed vectors push the odd-part terms into both saturation limits and the even-part sum into wraparound.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 14;
  localparam int ACC_W  = 2 * COEF_W + 2;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam acc_t HALF_LSB = acc_t'(1) <<< (FRAC_W - 1);
  localparam acc_t COEF_MAX = acc_t'((1 << (COEF_W - 1)) - 1);
  localparam acc_t COEF_MIN = -acc_t'(1 << (COEF_W - 1));

  // Rounded arithmetic shift, before clamping.
  function automatic acc_t round_shift(acc_t v);
    return (v + HALF_LSB) >>> FRAC_W;
  endfunction

  // Clamp a shifted value to the coefficient range.
  function automatic coef_t clamp(acc_t v);
    if (v > COEF_MAX) return coef_t'(COEF_MAX);
    if (v < COEF_MIN) return coef_t'(COEF_MIN);
    return coef_t'(v);
  endfunction
endpackage

// File: rtl/idct4_even.sv
module idct4_even
  import idct4_pkg::*;
#(
  parameter int K_MID = 11585
) (
  input  coef_t c0,
  input  coef_t c2,
  output acc_t  p0,
  output acc_t  p1
);
  coef_t e_sum;
  coef_t d_dif;

  // R4: 16-bit wrapping sum and difference
  assign e_sum = c0 + c2;
  assign d_dif = c0 - c2;

  assign p0 = acc_t'(e_sum) * acc_t'(K_MID);
  assign p1 = acc_t'(d_dif) * acc_t'(K_MID);
endmodule

// File: rtl/idct4_odd.sv
module idct4_odd
  import idct4_pkg::*;
#(
  parameter int K_HI = 15137,
  parameter int K_LO = 6270
) (
  input  coef_t c1,
  input  coef_t c3,
  output acc_t  p2,
  output acc_t  p3
);
  acc_t w1;
  acc_t w3;

  assign w1 = acc_t'(c1);
  assign w3 = acc_t'(c3);

  // R5: odd-part rotation at full precision
  assign p2 = w1 * acc_t'(K_LO) - w3 * acc_t'(K_HI);
  assign p3 = w1 * acc_t'(K_HI) + w3 * acc_t'(K_LO);
endmodule

// File: rtl/idct4_narrow.sv
module idct4_narrow
  import idct4_pkg::*;
(
  input  acc_t  p,
  output coef_t s,
  output logic  clip_hi,
  output logic  clip_lo
);
  acc_t shifted;

  // R6 rounding, R7 clamping
  assign shifted = round_shift(p);
  assign clip_hi = shifted > COEF_MAX;
  assign clip_lo = shifted < COEF_MIN;
  assign s       = clamp(shifted);
endmodule

// File: rtl/idct4_butterfly.sv
module idct4_butterfly
  import idct4_pkg::*;
(
  input  coef_t s0,
  input  coef_t s1,
  input  coef_t s2,
  input  coef_t s3,
  output coef_t y0,
  output coef_t y1,
  output coef_t y2,
  output coef_t y3
);
  // R8: wrapping recombination
  assign y0 = s0 + s3;
  assign y1 = s1 + s2;
  assign y2 = s1 - s2;
  assign y3 = s0 - s3;
endmodule

// File: rtl/idct4_q14.sv
module idct4_q14
  import idct4_pkg::*;
#(
  parameter int K_PI8  = 15137,
  parameter int K_PI4  = 11585,
  parameter int K_3PI8 = 6270,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [COEF_W-1:0] in_c0,
  input  logic signed [COEF_W-1:0] in_c1,
  input  logic signed [COEF_W-1:0] in_c2,
  input  logic signed [COEF_W-1:0] in_c3,
  output logic                     out_valid,
  output logic signed [COEF_W-1:0] out_y0,
  output logic signed [COEF_W-1:0] out_y1,
  output logic signed [COEF_W-1:0] out_y2,
  output logic signed [COEF_W-1:0] out_y3
);
  acc_t  step_raw [LANES];
  coef_t step_sat [LANES];
  logic  step_clip_hi [LANES];
  logic  step_clip_lo [LANES];
  coef_t step_sat0, step_sat1, step_sat2, step_sat3;
  coef_t comb_y0, comb_y1, comb_y2, comb_y3;
  logic  capture;

  idct4_even #(.K_MID(K_PI4)) u_even (
    .c0(in_c0), .c2(in_c2), .p0(step_raw[0]), .p1(step_raw[1])
  );

  idct4_odd #(.K_HI(K_PI8), .K_LO(K_3PI8)) u_odd (
    .c1(in_c1), .c3(in_c3), .p2(step_raw[2]), .p3(step_raw[3])
  );

  for (genvar i = 0; i < LANES; i++) begin : g_narrow
    idct4_narrow u_narrow (
      .p      (step_raw[i]),
      .s      (step_sat[i]),
      .clip_hi(step_clip_hi[i]),
      .clip_lo(step_clip_lo[i])
    );
  end

  assign step_sat0 = step_sat[0];
  assign step_sat1 = step_sat[1];
  assign step_sat2 = step_sat[2];
  assign step_sat3 = step_sat[3];

  idct4_butterfly u_bfly (
    .s0(step_sat0), .s1(step_sat1), .s2(step_sat2), .s3(step_sat3),
    .y0(comb_y0), .y1(comb_y1), .y2(comb_y2), .y3(comb_y3)
  );

  assign capture = in_valid;

  // R1 reset, R2 latency, R3 hold
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y0    <= '0;
      out_y1    <= '0;
      out_y2    <= '0;
      out_y3    <= '0;
    end else begin
      out_valid <= in_valid;
      if (capture) begin
        out_y0 <= comb_y0;
        out_y1 <= comb_y1;
        out_y2 <= comb_y2;
        out_y3 <= comb_y3;
      end
    end
  end
endmodule

// File: rtl/idct4_q14_chk.sv
module idct4_q14_chk
  import idct4_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  in_valid,
  input logic  out_valid,
  input coef_t out_y0,
  input coef_t out_y1,
  input coef_t out_y2,
  input coef_t out_y3,
  input coef_t step_sat0,
  input coef_t step_sat1,
  input coef_t step_sat2,
  input coef_t step_sat3,
  input logic  clip_hi3,
  input logic  clip_lo3
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y0 == 0 && out_y1 == 0 && out_y2 == 0 && out_y3 == 0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_hold_lanes: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2) && $stable(out_y3)));

  a_r8_even_pair: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (coef_t'(out_y0 + out_y3) == coef_t'($past(step_sat0) + $past(step_sat0))));

  a_r8_odd_pair: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (coef_t'(out_y1 - out_y2) == coef_t'($past(step_sat2) + $past(step_sat2))));

  a_r8_mixed_pair: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (coef_t'(out_y1 + out_y2) == coef_t'($past(step_sat1) + $past(step_sat1))));

  a_r7_clip_hi: assert property (@(posedge clk) disable iff (rst)
    clip_hi3 |-> (step_sat3 == 16'sh7fff && !clip_lo3));

  a_r7_clip_lo: assert property (@(posedge clk) disable iff (rst)
    clip_lo3 |-> (step_sat3 == 16'sh8000 && !clip_hi3));
endmodule

bind idct4_q14 idct4_q14_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3),
  .step_sat0(step_sat0), .step_sat1(step_sat1),
  .step_sat2(step_sat2), .step_sat3(step_sat3),
  .clip_hi3(step_clip_hi[3]), .clip_lo3(step_clip_lo[3])
);

// File: tb/idct4_q14_tb.sv
module idct4_q14_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
  logic out_valid;
  logic signed [15:0] y0, y1, y2, y3;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  idct4_q14 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_c0(c0), .in_c1(c1), .in_c2(c2), .in_c3(c3),
    .out_valid(out_valid),
    .out_y0(y0), .out_y1(y1), .out_y2(y2), .out_y3(y3)
  );

  // Model: sign-extend a 16-bit value into a longint.
  function automatic longint sx(logic [15:0] v);
    return (v >= 16'h8000) ? longint'(v) - 65536 : longint'(v);
  endfunction

  // Model: wrap a longint to its signed 16-bit value.
  function automatic longint wrap16(longint v);
    return sx(v[15:0]);
  endfunction

  // Model: floor((p + 8192) / 16384), then clamp.
  function automatic longint narrow(longint p);
    longint q, t;
    t = p + 8192;
    q = t / 16384;
    if ((t % 16384) != 0 && t < 0) q = q - 1;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic model(input longint a0, a1, a2, a3,
                       output longint e0, e1, e2, e3);
    longint s0, s1, s2, s3, ev, dv;
    ev = wrap16(a0 + a2);
    dv = wrap16(a0 - a2);
    s0 = narrow(ev * 11585);
    s1 = narrow(dv * 11585);
    s2 = narrow(a1 * 6270 - a3 * 15137);
    s3 = narrow(a1 * 15137 + a3 * 6270);
    e0 = wrap16(s0 + s3);
    e1 = wrap16(s1 + s2);
    e2 = wrap16(s1 - s2);
    e3 = wrap16(s0 - s3);
  endtask

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(string tag, longint a0, a1, a2, a3);
    longint e0, e1, e2, e3;
    model(a0, a1, a2, a3, e0, e1, e2, e3);
    @(negedge clk);
    c0 = a0[15:0]; c1 = a1[15:0]; c2 = a2[15:0]; c3 = a3[15:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R2"}, "out_valid", longint'(out_valid), 1);
    check(tag, "y0", sx(y0), e0);
    check(tag, "y1", sx(y1), e1);
    check(tag, "y2", sx(y2), e2);
    check(tag, "y3", sx(y3), e3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint h0, h1, h2, h3;
    void'($urandom(32'd7421));
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1", "out_valid", longint'(out_valid), 0);
    check("R1", "y0|y1|y2|y3", longint'(y0 | y1 | y2 | y3), 0);
    rst = 1'b0;

    // R5: constants seen directly (in1 = 1.0 in Q14)
    run_vec("R5", 0, 16384, 0, 0);
    run_vec("R5", 0, 0, 0, 16384);
    run_vec("R5", 16384, 0, 0, 0);
    // R6: rounding of halves and small values
    run_vec("R6", 1, 0, 0, 0);
    run_vec("R6", -1, 0, 0, 0);
    run_vec("R6", 1, 0, 1, 0);
    run_vec("R6", 0, 0, -1, 0);
    // R4: wrap of the even sum and difference
    run_vec("R4", 32767, 0, 1, 0);
    run_vec("R4", -32768, 0, 1, 0);
    // R7: odd term saturation at both limits
    run_vec("R7", 0, 32767, 0, 32767);
    run_vec("R7", 0, -32768, 0, -32768);
    run_vec("R7", 0, 32767, 0, -32768);
    run_vec("R7", -32768, -32768, -32768, -32768);
    run_vec("R7", 32767, 32767, 32767, 32767);

    // R3: idle cycles with new data must not change outputs
    h0 = sx(y0); h1 = sx(y1); h2 = sx(y2); h3 = sx(y3);
    @(negedge clk);
    c0 = 16'sd1234; c1 = -16'sd999; c2 = 16'sd77; c3 = 16'sd5000;
    in_valid = 1'b0;
    @(negedge clk);
    check("R3", "out_valid low", longint'(out_valid), 0);
    check("R3", "y0 held", sx(y0), h0);
    check("R3", "y1 held", sx(y1), h1);
    check("R3", "y2 held", sx(y2), h2);
    check("R3", "y3 held", sx(y3), h3);

    // R8: random full-range vectors
    for (int n = 0; n < 300; n++) begin
      run_vec("R8", sx(16'($urandom)), sx(16'($urandom)),
              sx(16'($urandom)), sx(16'($urandom)));
    end

    // R1: reset after activity clears everything
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", longint'(out_valid), 0);
    check("R1", "y0 after reset", sx(y0), 0);
    check("R1", "y3 after reset", sx(y3), 0);
    rst = 1'b0;
    in_valid = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule